// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Peripheral

This block gives a host processor three 8-bit general-purpose parallel ports: A, B and C. The host reaches them through a small register bus made of a chip select, read and write strobes, a 2-bit register address and separate 8-bit write and read data buses. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. Each of the four port groups drives an output latch onto its pins. An output-enable tells the pad ring when that group is driving.

One write-only control location has two meanings, chosen by bit 7 of the written byte:
- **Bit 7 = 1 (setup word):** the byte reprograms the direction and mode fields. It also clears every output latch to zero, even when the directions stay the same.
- **Bit 7 = 0 (bit command):** the byte sets or clears one chosen bit of the port C latch and leaves everything else alone.

Only plain input/output operation is built. The mode fields are stored but do not change how the ports behave.

Software that wants to keep a port value across a reconfiguration must write the value again after the setup word. The block is a register peripheral, not a streaming path, so it has no valid/ready handshake. A write takes effect in the cycle it is strobed. A read is answered combinationally in the cycle it is strobed.

Top module: `ppi_core`

## Requirements
- R1: After reset every group is an input, every output-enable is low, all three output latches are 00h and all mode fields are 0.
- R2: A write to address 0, 1 or 2 (port A, B, C) loads that port's whole output latch on the clock edge, whatever the port's direction. The new value appears on the matching `*_out` bus after that edge.
- R3: A control write (address 3) with bit 7 = 1 sets the directions from four bits, where 1 means input and 0 means output: bit 4 for port A, bit 1 for port B, bit 3 for the upper nibble of C and bit 0 for the lower nibble of C. Each output-enable is high exactly when its group is an output. Bits 6:5 and bit 2 are mode fields and have no effect on the ports.
- R4: Every control write with bit 7 = 1 clears the A, B and C output latches to 00h, including when no direction changes.
- R5: A control write with bit 7 = 0 writes bit 0 into the port C latch bit numbered by bits 3:1 (0 to 7). It ignores bits 6:4. It leaves every other port C latch bit, the A and B latches and all directions unchanged.
- R6: A read of port A or B returns the latch when the port is an output and the input pins when it is an input. A read of port C builds each nibble the same way, using that nibble's own direction.
- R7: A read of the control address returns 00h. When chip select or the read strobe is low, the read data is 00h.
- R8: Setup word 82h makes A an output, B an input and both C nibbles outputs. Setup word 92h makes A and B inputs and both C nibbles outputs.
- R9: No state changes on a clock edge where chip select or the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C output latch |
| pc_oe_hi | output | 1 | Drive enable, port C bits 7:4 |
| pc_oe_lo | output | 1 | Drive enable, port C bits 3:0 |

## Verification
The bench issues setup words that repeat the current directions and checks that the latches still drop to zero. A design that cleared the latches only on a real direction change would keep the old values. Between setup words it walks bit commands across all eight port C bits and watches A and B. A decoder that treated a bit command as a setup word would wipe them, and a wrong bit index would hit the wrong port C bit. Random traffic with random pins and gated strobes catches two further faults: a nibble of port C read with the other nibble's direction, and writes that leak through without chip select.

// File: rtl/ppi_pkg.sv
`timescale 1ns/1ps
package ppi_pkg;
  localparam int unsigned PPI_DW = 8;
  localparam int unsigned PPI_AW = 2;

  typedef enum logic [PPI_AW-1:0] {
    REG_A    = 2'd0,
    REG_B    = 2'd1,
    REG_C    = 2'd2,
    REG_CTRL = 2'd3
  } ppi_reg_e;

  typedef struct packed {
    logic [1:0] mode_hi;  // group A / upper C mode, stored only
    logic       mode_lo;  // group B / lower C mode, stored only
    logic       in_a;
    logic       in_b;
    logic       in_ch;
    logic       in_cl;
  } ppi_cfg_t;

  localparam ppi_cfg_t CFG_RESET = '{mode_hi: 2'b00, mode_lo: 1'b0,
                                     in_a: 1'b1, in_b: 1'b1,
                                     in_ch: 1'b1, in_cl: 1'b1};
endpackage

// File: rtl/ppi_ctrl.sv
`timescale 1ns/1ps
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int unsigned DW = PPI_DW,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wdata,
  output ppi_cfg_t      cfg,
  output logic          setup_stb,
  output logic          bitop_stb,
  output logic [IW-1:0] bit_idx,
  output logic          bit_val
);
  assign setup_stb = ctrl_we &  wdata[DW-1];
  assign bitop_stb = ctrl_we & ~wdata[DW-1];
  assign bit_idx   = wdata[IW:1];
  assign bit_val   = wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (setup_stb) begin
      cfg.in_cl   <= wdata[0];
      cfg.in_b    <= wdata[1];
      cfg.mode_lo <= wdata[2];
      cfg.in_ch   <= wdata[3];
      cfg.in_a    <= wdata[4];
      cfg.mode_hi <= wdata[6:5];
    end
  end

  // R5 / R9: direction state only moves on a setup word
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_stb |=> $stable(cfg));
  a_r3_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |=> (cfg.in_a == $past(wdata[4])) && (cfg.in_cl == $past(wdata[0])));
endmodule

// File: rtl/ppi_latches.sv
`timescale 1ns/1ps
module ppi_latches
  import ppi_pkg::*;
#(
  parameter int unsigned DW = PPI_DW,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic          we_b,
  input  logic          we_c,
  input  logic          clr_all,
  input  logic          bitop,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lat_a,
  output logic [DW-1:0] lat_b,
  output logic [DW-1:0] lat_c
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) lat_a <= '0;
    else if (we_a)         lat_a <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) lat_b <= '0;
    else if (we_b)         lat_b <= wdata;
  end

  for (genvar i = 0; i < DW; i++) begin : g_cbit
    logic hit;
    assign hit = bitop && (bit_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) lat_c[i] <= 1'b0;
      else if (we_c)         lat_c[i] <= wdata[i];
      else if (hit)          lat_c[i] <= bit_val;
    end
  end

  // R5: a bit command moves at most one bit of port C
  a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bitop && !clr_all) |=> ($countones(lat_c ^ $past(lat_c)) <= 1));
endmodule

// File: rtl/ppi_rdmux.sv
`timescale 1ns/1ps
module ppi_rdmux
  import ppi_pkg::*;
#(
  parameter int unsigned DW = PPI_DW,
  localparam int unsigned NB = DW / 2
) (
  input  logic              rd_en,
  input  logic [PPI_AW-1:0] addr,
  input  ppi_cfg_t          cfg,
  input  logic [DW-1:0]     lat_a,
  input  logic [DW-1:0]     lat_b,
  input  logic [DW-1:0]     lat_c,
  input  logic [DW-1:0]     pin_a,
  input  logic [DW-1:0]     pin_b,
  input  logic [DW-1:0]     pin_c,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] c_view;

  assign c_view[DW-1:NB] = cfg.in_ch ? pin_c[DW-1:NB] : lat_c[DW-1:NB];
  assign c_view[NB-1:0]  = cfg.in_cl ? pin_c[NB-1:0]  : lat_c[NB-1:0];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (ppi_reg_e'(addr))
        REG_A:    rdata = cfg.in_a ? pin_a : lat_a;
        REG_B:    rdata = cfg.in_b ? pin_b : lat_b;
        REG_C:    rdata = c_view;
        REG_CTRL: rdata = '0;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_core.sv
`timescale 1ns/1ps
module ppi_core
  import ppi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  pa_in,
  output logic [7:0]  pa_out,
  output logic        pa_oe,
  input  logic [7:0]  pb_in,
  output logic [7:0]  pb_out,
  output logic        pb_oe,
  input  logic [7:0]  pc_in,
  output logic [7:0]  pc_out,
  output logic        pc_oe_hi,
  output logic        pc_oe_lo
);
  localparam int unsigned DW = PPI_DW;
  localparam int unsigned IW = $clog2(DW);

  logic          wr_en;
  logic          setup_stb, bitop_stb, bit_val;
  logic [IW-1:0] bit_idx;
  ppi_cfg_t      cfg;

  assign wr_en = cs & wr;

  ppi_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr_en && (addr == REG_CTRL)),
    .wdata(wdata), .cfg(cfg),
    .setup_stb(setup_stb), .bitop_stb(bitop_stb),
    .bit_idx(bit_idx), .bit_val(bit_val)
  );

  ppi_latches #(.DW(DW)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .we_a(wr_en && (addr == REG_A)),
    .we_b(wr_en && (addr == REG_B)),
    .we_c(wr_en && (addr == REG_C)),
    .clr_all(setup_stb), .bitop(bitop_stb),
    .bit_idx(bit_idx), .bit_val(bit_val), .wdata(wdata),
    .lat_a(pa_out), .lat_b(pb_out), .lat_c(pc_out)
  );

  ppi_rdmux #(.DW(DW)) u_rd (
    .rd_en(cs & rd), .addr(addr), .cfg(cfg),
    .lat_a(pa_out), .lat_b(pb_out), .lat_c(pc_out),
    .pin_a(pa_in), .pin_b(pb_in), .pin_c(pc_in),
    .rdata(rdata)
  );

  assign pa_oe    = ~cfg.in_a;
  assign pb_oe    = ~cfg.in_b;
  assign pc_oe_hi = ~cfg.in_ch;
  assign pc_oe_lo = ~cfg.in_cl;

  // R2: port writes land in the latch
  a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd0) |=> pa_out == $past(wdata));
  // R4: setup word clears all latches
  a_r4_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));
  // R5: bit command keeps A, B and drive enables
  a_r5_keep_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && !wdata[7]) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pc_oe_hi)));
  // R9: no strobe, no change
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pb_oe) && $stable(pc_oe_lo)));
  // R7: control location reads zero
  a_r7_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3 || !cs || !rd) |-> rdata == 8'h00);
endmodule

// File: tb/ppi_core_test.sv
`timescale 1ns/1ps
module ppi_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_in, pb_in, pc_in, pa_out, pb_out, pc_out;
  logic       pa_oe, pb_oe, pc_oe_hi, pc_oe_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [7:0] ma, mb, mc;
  logic ia, ib, ich, icl;

  always #4 clk = ~clk;

  ppi_core uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe_hi(pc_oe_hi), .pc_oe_lo(pc_oe_lo)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return ia ? pa_in : ma;
      2'd1: return ib ? pb_in : mb;
      2'd2: return {ich ? pc_in[7:4] : mc[7:4], icl ? pc_in[3:0] : mc[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(logic [1:0] a, logic [7:0] d);
    case (a)
      2'd0: ma = d;
      2'd1: mb = d;
      2'd2: mc = d;
      default: begin
        if (d[7]) begin
          icl = d[0]; ib = d[1]; ich = d[3]; ia = d[4];
          ma = 8'h00; mb = 8'h00; mc = 8'h00;
        end else begin
          mc[d[3:1]] = d[0];
        end
      end
    endcase
  endtask

  // drive at falling edge, commit on rising edge, release at next falling edge
  task automatic bus_write(logic [1:0] a, logic [7:0] d, logic c, logic w);
    @(negedge clk);
    cs = c; wr = w; rd = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (c && w) model_write(a, d);
  endtask

  task automatic check_outputs(string req);
    chk(req, "pa_out", pa_out, ma);
    chk(req, "pb_out", pb_out, mb);
    chk(req, "pc_out", pc_out, mc);
    chk(req, "oe", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, {~ia, ~ib, ~ich, ~icl});
  endtask

  task automatic check_reads(string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = 2'(i);
      #1;
      chk(req, $sformatf("read addr %0d", i), rdata, exp_read(2'(i)));
      cs = 1'b0; rd = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20180610));
    pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h96;
    ma = 0; mb = 0; mc = 0; ia = 1; ib = 1; ich = 1; icl = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R6 input reads
    check_outputs("R1");
    check_reads("R6");

    // R2 write while input: latch loads, reads still show pins
    bus_write(2'd0, 8'h11, 1, 1);
    chk("R2", "pa_out while input", pa_out, 8'h11);
    check_reads("R6");

    // R8 82h
    bus_write(2'd3, 8'h82, 1, 1);
    chk("R8", "oe after 82h", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, 4'b1011);
    chk("R4", "latch A cleared by 82h", pa_out, 8'h00);
    bus_write(2'd0, 8'h5A, 1, 1);
    bus_write(2'd2, 8'hF0, 1, 1);
    check_reads("R6");

    // R8 92h
    bus_write(2'd3, 8'h92, 1, 1);
    chk("R8", "oe after 92h", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, 4'b0011);
    check_outputs("R3");

    // R4 same directions rewritten still clears; R3 mode bits no effect
    bus_write(2'd3, 8'h80, 1, 1);
    bus_write(2'd0, 8'h5A, 1, 1);
    bus_write(2'd1, 8'hC3, 1, 1);
    bus_write(2'd2, 8'h7E, 1, 1);
    bus_write(2'd3, 8'hE4, 1, 1);
    chk("R4", "A cleared same dir", pa_out, 8'h00);
    chk("R4", "C cleared same dir", pc_out, 8'h00);
    chk("R3", "mode bits leave outputs driven", {pa_oe, pb_oe, pc_oe_hi, pc_oe_lo}, 4'b1111);

    // R5 toggle C bits between setups, A and B must hold
    bus_write(2'd0, 8'h5A, 1, 1);
    bus_write(2'd1, 8'hC3, 1, 1);
    for (int b = 0; b < 8; b++) begin
      bus_write(2'd3, {4'b0111, 3'(b), 1'b1}, 1, 1);  // bits 6:4 set, ignored
      chk("R5", $sformatf("pc_out after set %0d", b), pc_out, mc);
      chk("R5", "pa_out held", pa_out, 8'h5A);
      chk("R5", "pb_out held", pb_out, 8'hC3);
    end
    chk("R5", "all C bits set", pc_out, 8'hFF);
    for (int b = 7; b >= 0; b -= 2) begin
      bus_write(2'd3, {4'b0000, 3'(b), 1'b0}, 1, 1);
      chk("R5", "pc_out after clear", pc_out, mc);
    end
    chk("R5", "odd bits cleared", pc_out, 8'h55);
    check_outputs("R5");
    bus_write(2'd3, 8'h80, 1, 1);
    check_outputs("R4");

    // R9 gated writes
    bus_write(2'd1, 8'hEE, 0, 1);
    bus_write(2'd1, 8'hEE, 1, 0);
    bus_write(2'd3, 8'h9B, 0, 1);
    check_outputs("R9");

    // R7 read without strobe
    @(negedge clk);
    cs = 1'b1; rd = 1'b0; addr = 2'd0; #1;
    chk("R7", "rdata without rd", rdata, 8'h00);
    cs = 1'b0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [1:0] ra;
      logic [7:0] rv;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      ra = 2'($urandom);
      rv = 8'($urandom);
      if (ra == 2'd3 && ($urandom % 4) != 0) rv[7] = 1'b0;
      bus_write(ra, rv, ($urandom % 8) != 0, ($urandom % 8) != 0);
      check_outputs("R9");
      check_reads("R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule